// File: doc/BRIEF.md
# Two-Mode Priority Interrupt Controller

This block chooses which pending interrupt a small processor takes next. Peripheral and external request lines are captured into pending bits. Each line counts only while its own enable bit is set. A separate non-maskable input is caught on its rising edge. Two masking schemes are available, picked by a mode input. The single-bit mode uses one global mask flag and ranks sources only by index. The level mode compares each source's 3-bit priority field against a 3-bit mask level.

The processor raises a strobe at every instruction boundary, and a choice is made only on that strobe. The cycle after an acceptance, the block gives a one-cycle accept pulse with the winner's vector number. In the same cycle it presents the captured next-instruction address and condition code to an external stack writer. It also raises the mask so that further maskable requests wait. The processor can load the mask state through a write port, for example when it returns from a handler.

Top module: `intc_core`

## Requirements
- R1: A request line whose enable bit is 0 is neither latched nor accepted.
- R2: In single-bit mode (mode_i = 0), maskable requests are accepted while mask_bit_o is 0 and blocked while it is 1.
- R3: A blocked request stays pending and is accepted at the first boundary after the mask opens.
- R4: When several requests are eligible, only the highest-ranked one is accepted. The others stay pending and are accepted at later boundaries.
- R5: An acceptance happens only on a clock edge where boundary_i is 1. accept_o is high for exactly the cycle after that edge.
- R6: With accept_o, save_pc_o and save_ccr_o show the pc_i and ccr_i values sampled at the accepting edge.
- R7: In single-bit mode, every acceptance sets mask_bit_o to 1.
- R8: In level mode (mode_i = 1), source i's priority is prio_i[3i+2:3i]. A source is eligible only when its level is strictly above mask_lvl_o, or when its level is 7. On acceptance, mask_lvl_o takes the accepted level.
- R9: The non-maskable input is accepted on its rising edge even while the mask blocks other requests, and it ranks above every source. Holding it high does not cause a second acceptance. In level mode its acceptance sets mask_lvl_o to 7.
- R10: Among eligible sources of equal rank, the lower index wins. In single-bit mode, all sources have equal rank.
- R11: The vector is VEC_BASE + source index (16 + i by default). The non-maskable input uses the fixed vector NMI_VEC (7 by default). vector_o is 0 when accept_o is low.
- R12: Reset sets mask_bit_o to 1 and mask_lvl_o to 7 and clears all pending state. When mask_we_i is 1, the next edge loads mask_bit_wr_i and mask_lvl_wr_i, except that an acceptance on the same edge overrides the loaded mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_SRC | Request lines, one per source |
| en_i | input | NUM_SRC | Per-source enable bits |
| nmi_i | input | 1 | Non-maskable interrupt input, edge detected |
| mode_i | input | 1 | 0 = single-bit mask, 1 = eight-level mask |
| prio_i | input | 3*NUM_SRC | Per-source 3-bit priority fields |
| boundary_i | input | 1 | Instruction-boundary strobe |
| pc_i | input | PC_W | Address of next instruction |
| ccr_i | input | CCR_W | Current condition code value |
| mask_we_i | input | 1 | Write strobe for mask state |
| mask_bit_wr_i | input | 1 | New single mask bit |
| mask_lvl_wr_i | input | 3 | New 3-bit mask level |
| accept_o | output | 1 | One-cycle accept pulse |
| vector_o | output | VEC_W | Vector number of accepted source |
| mask_bit_o | output | 1 | Current single mask bit |
| mask_lvl_o | output | 3 | Current 3-bit mask level |
| save_pc_o | output | PC_W | Program counter for the stack writer |
| save_ccr_o | output | CCR_W | Condition code for the stack writer |

## Verification
The hardest case to reach is a request that has lost or been blocked, and must still be pending much later. The losing request is a one-cycle pulse, so only the pending latch remembers it. The stimulus pulses two requests together, or one request under a closed mask, and then takes the request lines low. It reopens the mask through the write port and issues a fresh boundary strobe. The vector that appears then can only come from the latched state. A second hard case is a non-maskable input held high across several boundaries. The stimulus keeps it high and checks that no further acceptance occurs.

// File: rtl/intc_pkg.sv
package intc_pkg;
    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_LEVEL  = 1'b1
    } intc_mode_e;

    localparam int LVL_W = 3;
    localparam logic [LVL_W-1:0] LVL_TOP = '1;
endpackage

// File: rtl/intc_pending.sv
module intc_pending #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic               nmi_i,
    input  logic [NUM_SRC-1:0] clr_src_i,
    input  logic               clr_nmi_i,
    output logic [NUM_SRC-1:0] cand_o,
    output logic               nmi_cand_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
        logic               nmi_prev;
        logic               nmi_pend;
    } pend_t;

    pend_t st_d, st_q;
    logic [NUM_SRC-1:0] live;
    logic               nmi_rise;

    always_comb begin
        live        = req_i & en_i;
        nmi_rise    = nmi_i & ~st_q.nmi_prev;
        cand_o      = (st_q.pend | live) & en_i;
        nmi_cand_o  = st_q.nmi_pend | nmi_rise;
        st_d.pend     = (st_q.pend | live) & ~clr_src_i;
        st_d.nmi_prev = nmi_i;
        st_d.nmi_pend = nmi_cand_o & ~clr_nmi_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0]       cand_i,
    input  logic [NUM_SRC*LVL_W-1:0] prio_i,
    input  intc_mode_e               mode_i,
    input  logic                     mask_bit_i,
    input  logic [LVL_W-1:0]         mask_lvl_i,
    output logic                     hit_o,
    output logic [IDX_W-1:0]         win_idx_o,
    output logic [LVL_W-1:0]         win_lvl_o
);
    logic [NUM_SRC-1:0]   elig;
    logic [LVL_W-1:0]     rank [NUM_SRC];

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic [LVL_W-1:0] lvl;
        assign lvl = prio_i[g*LVL_W +: LVL_W];
        assign rank[g] = (mode_i == MODE_LEVEL) ? lvl : '0;
        assign elig[g] = cand_i[g] &
            ((mode_i == MODE_SINGLE) ? ~mask_bit_i
                                     : ((lvl > mask_lvl_i) || (lvl == LVL_TOP)));
    end

    // Downward scan with >= lets the lower index win ties
    always_comb begin
        hit_o     = 1'b0;
        win_idx_o = '0;
        win_lvl_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig[i] && (!hit_o || rank[i] >= win_lvl_o)) begin
                hit_o     = 1'b1;
                win_idx_o = IDX_W'(i);
                win_lvl_o = rank[i];
            end
        end
    end
endmodule

// File: rtl/intc_core.sv
module intc_core
    import intc_pkg::*;
#(
    parameter int NUM_SRC  = 8,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 16,
    parameter int NMI_VEC  = 7,
    parameter int PC_W     = 32,
    parameter int CCR_W    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       req_i,
    input  logic [NUM_SRC-1:0]       en_i,
    input  logic                     nmi_i,
    input  logic                     mode_i,
    input  logic [NUM_SRC*3-1:0]     prio_i,
    input  logic                     boundary_i,
    input  logic [PC_W-1:0]          pc_i,
    input  logic [CCR_W-1:0]         ccr_i,
    input  logic                     mask_we_i,
    input  logic                     mask_bit_wr_i,
    input  logic [2:0]               mask_lvl_wr_i,
    output logic                     accept_o,
    output logic [VEC_W-1:0]         vector_o,
    output logic                     mask_bit_o,
    output logic [2:0]               mask_lvl_o,
    output logic [PC_W-1:0]          save_pc_o,
    output logic [CCR_W-1:0]         save_ccr_o
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    typedef struct packed {
        logic             accept;
        logic [VEC_W-1:0] vector;
        logic             mask_bit;
        logic [LVL_W-1:0] mask_lvl;
        logic [PC_W-1:0]  save_pc;
        logic [CCR_W-1:0] save_ccr;
    } core_t;

    core_t st_d, st_q;

    intc_mode_e         mode;
    logic [NUM_SRC-1:0] cand;
    logic               nmi_cand;
    logic [NUM_SRC-1:0] clr_src;
    logic               clr_nmi;
    logic               hit;
    logic [IDX_W-1:0]   win_idx;
    logic [LVL_W-1:0]   win_lvl;

    assign mode = intc_mode_e'(mode_i);

    intc_pending #(.NUM_SRC(NUM_SRC)) i_pending (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .en_i       (en_i),
        .nmi_i      (nmi_i),
        .clr_src_i  (clr_src),
        .clr_nmi_i  (clr_nmi),
        .cand_o     (cand),
        .nmi_cand_o (nmi_cand)
    );

    intc_arbiter #(.NUM_SRC(NUM_SRC)) i_arbiter (
        .cand_i     (cand),
        .prio_i     (prio_i),
        .mode_i     (mode),
        .mask_bit_i (st_q.mask_bit),
        .mask_lvl_i (st_q.mask_lvl),
        .hit_o      (hit),
        .win_idx_o  (win_idx),
        .win_lvl_o  (win_lvl)
    );

    always_comb begin
        st_d        = st_q;
        st_d.accept = 1'b0;
        st_d.vector = '0;
        clr_src     = '0;
        clr_nmi     = 1'b0;

        if (mask_we_i) begin
            st_d.mask_bit = mask_bit_wr_i;
            st_d.mask_lvl = mask_lvl_wr_i;
        end

        if (boundary_i && (nmi_cand || hit)) begin
            st_d.accept   = 1'b1;
            st_d.save_pc  = pc_i;
            st_d.save_ccr = ccr_i;
            if (nmi_cand) begin
                clr_nmi     = 1'b1;
                st_d.vector = VEC_W'(NMI_VEC);
                if (mode == MODE_LEVEL) st_d.mask_lvl = LVL_TOP;
                else                    st_d.mask_bit = 1'b1;
            end else begin
                clr_src[win_idx] = 1'b1;
                st_d.vector = VEC_W'(VEC_BASE) + VEC_W'(win_idx);
                if (mode == MODE_LEVEL) st_d.mask_lvl = win_lvl;
                else                    st_d.mask_bit = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.mask_bit <= 1'b1;
            st_q.mask_lvl <= LVL_TOP;
        end else begin
            st_q <= st_d;
        end
    end

    assign accept_o   = st_q.accept;
    assign vector_o   = st_q.vector;
    assign mask_bit_o = st_q.mask_bit;
    assign mask_lvl_o = st_q.mask_lvl;
    assign save_pc_o  = st_q.save_pc;
    assign save_ccr_o = st_q.save_ccr;
endmodule

// File: rtl/intc_core_chk.sv
module intc_core_chk #(
    parameter int NUM_SRC  = 8,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 16,
    parameter int NMI_VEC  = 7,
    parameter int PC_W     = 32,
    parameter int CCR_W    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_i,
    input logic             boundary_i,
    input logic [PC_W-1:0]  pc_i,
    input logic [CCR_W-1:0] ccr_i,
    input logic             accept_o,
    input logic [VEC_W-1:0] vector_o,
    input logic             mask_bit_o,
    input logic [2:0]       mask_lvl_o,
    input logic [PC_W-1:0]  save_pc_o,
    input logic [CCR_W-1:0] save_ccr_o
);
    // R5
    boundary_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> $past(boundary_i));

    // R6
    save_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> (save_pc_o == $past(pc_i) && save_ccr_o == $past(ccr_i)));

    // R7
    single_mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && !$past(mode_i)) |-> mask_bit_o);

    // R2
    blocked_only_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && !$past(mode_i) && $past(mask_bit_o)) |-> (vector_o == VEC_W'(NMI_VEC)));

    // R9
    nmi_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && $past(mode_i) && vector_o == VEC_W'(NMI_VEC)) |-> (mask_lvl_o == 3'd7));

    // R11
    vector_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> (vector_o == VEC_W'(NMI_VEC) ||
                      (vector_o >= VEC_W'(VEC_BASE) && vector_o < VEC_W'(VEC_BASE + NUM_SRC))));

    // R11
    idle_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_o |-> (vector_o == '0));
endmodule

bind intc_core intc_core_chk #(
    .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE),
    .NMI_VEC(NMI_VEC), .PC_W(PC_W), .CCR_W(CCR_W)
) i_intc_core_chk (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .boundary_i(boundary_i),
    .pc_i(pc_i), .ccr_i(ccr_i), .accept_o(accept_o), .vector_o(vector_o),
    .mask_bit_o(mask_bit_o), .mask_lvl_o(mask_lvl_o),
    .save_pc_o(save_pc_o), .save_ccr_o(save_ccr_o)
);

// File: tb/test_intc_core.sv
module test_intc_core;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [N-1:0] req_i, en_i;
    logic        nmi_i, mode_i, boundary_i, mask_we_i, mask_bit_wr_i;
    logic [N*3-1:0] prio_i;
    logic [31:0] pc_i;
    logic [7:0]  ccr_i;
    logic [2:0]  mask_lvl_wr_i;
    logic        accept_o, mask_bit_o;
    logic [7:0]  vector_o;
    logic [2:0]  mask_lvl_o;
    logic [31:0] save_pc_o;
    logic [7:0]  save_ccr_o;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intc_core i_intc_core (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .en_i(en_i), .nmi_i(nmi_i),
        .mode_i(mode_i), .prio_i(prio_i), .boundary_i(boundary_i),
        .pc_i(pc_i), .ccr_i(ccr_i), .mask_we_i(mask_we_i),
        .mask_bit_wr_i(mask_bit_wr_i), .mask_lvl_wr_i(mask_lvl_wr_i),
        .accept_o(accept_o), .vector_o(vector_o), .mask_bit_o(mask_bit_o),
        .mask_lvl_o(mask_lvl_o), .save_pc_o(save_pc_o), .save_ccr_o(save_ccr_o)
    );

    typedef struct packed {
        logic        mode;
        logic [2:0]  mask;
        logic [7:0]  en;
        logic [7:0]  req;
        logic [23:0] prio;
        logic        acc;
        logic [7:0]  vec;
        logic [2:0]  exp_mask;
    } row_t;

    localparam row_t ROWS [9] = '{
        '{1'b0, 3'd0, 8'hFF, 8'h04, 24'h0,      1'b1, 8'd18, 3'd1}, // R2 open
        '{1'b0, 3'd1, 8'hFF, 8'h04, 24'h0,      1'b0, 8'd0,  3'd1}, // R2 closed
        '{1'b0, 3'd0, 8'hFB, 8'h04, 24'h0,      1'b0, 8'd0,  3'd0}, // R1 disabled
        '{1'b0, 3'd0, 8'hFF, 8'h28, 24'h0,      1'b1, 8'd19, 3'd1}, // R10 index order
        '{1'b1, 3'd3, 8'hFF, 8'h04, 24'h000100, 1'b1, 8'd18, 3'd4}, // R8 above mask
        '{1'b1, 3'd4, 8'hFF, 8'h04, 24'h000100, 1'b0, 8'd0,  3'd4}, // R8 equal blocked
        '{1'b1, 3'd7, 8'hFF, 8'h04, 24'h0001C0, 1'b1, 8'd18, 3'd7}, // R8 level 7
        '{1'b1, 3'd0, 8'hFF, 8'h22, 24'h030010, 1'b1, 8'd21, 3'd6}, // R4 higher level
        '{1'b1, 3'd0, 8'hFF, 8'h48, 24'h140A00, 1'b1, 8'd19, 3'd5}  // R10 tie
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_i = '0; en_i = '1; nmi_i = 1'b0; mode_i = 1'b0;
        boundary_i = 1'b0; mask_we_i = 1'b0; mask_bit_wr_i = 1'b0;
        mask_lvl_wr_i = '0; prio_i = '0; pc_i = '0; ccr_i = '0;
        step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic write_mask(input logic b, input logic [2:0] l);
        mask_we_i = 1'b1; mask_bit_wr_i = b; mask_lvl_wr_i = l;
        step();
        mask_we_i = 1'b0;
    endtask

    task automatic pulse_req(input logic [N-1:0] r);
        req_i = r;
        step();
        req_i = '0;
    endtask

    task automatic boundary();
        boundary_i = 1'b1;
        step();
        boundary_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL R5 watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        // R12 reset values
        chk("R12 reset mask bit", 32'(mask_bit_o), 32'd1);
        chk("R12 reset mask lvl", 32'(mask_lvl_o), 32'd7);
        chk("R5 reset accept", 32'(accept_o), 32'd0);

        for (int k = 0; k < 9; k++) begin
            do_reset();
            mode_i = ROWS[k].mode; prio_i = ROWS[k].prio; en_i = ROWS[k].en;
            write_mask(ROWS[k].mask[0], ROWS[k].mask);
            pulse_req(ROWS[k].req);
            boundary();
            chk($sformatf("row%0d accept", k), 32'(accept_o), 32'(ROWS[k].acc));
            if (ROWS[k].acc) chk($sformatf("row%0d R11 vector", k), 32'(vector_o), 32'(ROWS[k].vec));
            if (ROWS[k].mode) chk($sformatf("row%0d R8 level", k), 32'(mask_lvl_o), 32'(ROWS[k].exp_mask));
            else chk($sformatf("row%0d R7 bit", k), 32'(mask_bit_o), 32'(ROWS[k].exp_mask[0]));
        end

        // R3 blocked request survives until unmasked
        do_reset();
        pulse_req(8'h01);
        boundary();
        chk("R3 blocked", 32'(accept_o), 32'd0);
        write_mask(1'b0, 3'd0);
        boundary();
        chk("R3 later accept", 32'(accept_o), 32'd1);
        chk("R3 vector", 32'(vector_o), 32'd16);

        // R4 loser stays pending
        do_reset();
        write_mask(1'b0, 3'd0);
        pulse_req(8'h28);
        boundary();
        chk("R4 first vector", 32'(vector_o), 32'd19);
        write_mask(1'b0, 3'd0);
        boundary();
        chk("R4 loser vector", 32'(vector_o), 32'd21);

        // R5 no acceptance without strobe; single-cycle pulse; R6 context
        do_reset();
        write_mask(1'b0, 3'd0);
        pulse_req(8'h02);
        step(); step(); step();
        chk("R5 no strobe", 32'(accept_o), 32'd0);
        pc_i = 32'h0000_1234; ccr_i = 8'h5A;
        boundary();
        chk("R5 accept", 32'(accept_o), 32'd1);
        chk("R6 pc", save_pc_o, 32'h0000_1234);
        chk("R6 ccr", 32'(save_ccr_o), 32'h5A);
        step();
        chk("R5 pulse ends", 32'(accept_o), 32'd0);

        // R9 NMI through closed mask, held high no retrigger, R11 vector
        do_reset();
        nmi_i = 1'b1;
        step();
        boundary();
        chk("R9 nmi accept", 32'(accept_o), 32'd1);
        chk("R11 nmi vector", 32'(vector_o), 32'd7);
        boundary();
        chk("R9 held no retrigger", 32'(accept_o), 32'd0);
        nmi_i = 1'b0;

        // R9 NMI beats maskable source, level mode sets 7
        do_reset();
        mode_i = 1'b1; prio_i = 24'h0001C0;
        write_mask(1'b0, 3'd0);
        req_i = 8'h04; nmi_i = 1'b1;
        step();
        req_i = '0;
        boundary();
        chk("R9 nmi wins", 32'(vector_o), 32'd7);
        chk("R9 nmi level", 32'(mask_lvl_o), 32'd7);
        nmi_i = 1'b0;

        // R12 acceptance overrides simultaneous mask write
        do_reset();
        write_mask(1'b0, 3'd0);
        pulse_req(8'h10);
        mask_we_i = 1'b1; mask_bit_wr_i = 1'b0; boundary_i = 1'b1;
        step();
        mask_we_i = 1'b0; boundary_i = 1'b0;
        chk("R12 accept wins", 32'(mask_bit_o), 32'd1);
        chk("R12 vector", 32'(vector_o), 32'd20);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule